// File: doc/BRIEF.md
# Machine-Mode Control Register Access Unit

This unit carries out the six control-register instructions of a 32-bit integer core against a small bank of machine-level registers. These are write, set-bits and clear-bits, each in a register-operand form and an immediate form. The decode stage supplies the minor opcode, the 12-bit register address, the first source register's value, the raw 5-bit source field and a flag that says whether the destination index is zero. In the same cycle the unit returns the old register value for write-back. It raises a write-back enable and an illegal-instruction flag, and at the next clock edge it commits the read-modify-write.

The bank holds a scratch register, a hart-number register and two free-running counters. The hart-number register is loaded from an input while reset is held and is read-only after that. One counter counts clock cycles. The other counts retirement pulses from the pipeline. A software write to either counter wins over its increment in that cycle. Whether the read and the write happen at all depends on the destination flag and on the source field, so an instruction used only as a read or only as a write has no side effect on the other path.

Top module: `csr_unit`

## Requirements
- R1: The implemented addresses are 0x340 (scratch, read/write), 0xF14 (hart number, read-only), 0xB00 (cycle counter, read/write) and 0xB02 (retired counter, read/write). An access to any other address raises `illegal_o`.
- R2: Minor opcode 1 and 5 write the operand. Opcodes 2 and 6 write old OR operand. Opcodes 3 and 7 write old AND NOT operand. Opcodes 0 and 4 raise `illegal_o`. `rdata_o` shows the old value of the addressed register in the same cycle, and the new value is visible from the next cycle on.
- R3: Opcodes 5, 6 and 7 take the 5-bit source field, zero-extended to 32 bits, as the operand and ignore `rs1_val_i`.
- R4: A write form (opcode 1 or 5) with `rd_zero_i` high still writes the register but does not assert `wb_en_o`.
- R5: A set or clear form whose 5-bit source field is zero is a pure read: no register changes.
- R6: `wb_en_o` is high exactly when `valid_i` is high, `illegal_o` is low and `rd_zero_i` is low.
- R7: A write to an address whose bits [11:10] are 2'b11 raises `illegal_o`. An illegal access changes no register. A set or clear with a zero source field counts as a read and is legal on such an address.
- R8: The hart-number register takes the value of `hart_id_i` on every clock edge while `rst_n` is low and keeps it afterwards, whatever `hart_id_i` does.
- R9: The cycle counter adds one on every clock edge out of reset and wraps from 0xFFFFFFFF to 0. A write to it in a cycle replaces that cycle's increment.
- R10: The retired counter adds one on each edge where `retire_i` is high. A write to it in the same cycle takes precedence.
- R11: Synchronous reset clears the scratch register and both counters.
- R12: With `valid_i` low no register is written, and `wb_en_o` and `illegal_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hart_id_i | input | 32 | Hart number, captured during reset |
| valid_i | input | 1 | A control-register instruction is executing this cycle |
| funct3_i | input | 3 | Minor opcode of the instruction |
| addr_i | input | 12 | Register address |
| rs1_val_i | input | 32 | Value of the first source register |
| rs1_fld_i | input | 5 | Raw source field (immediate operand and zero test) |
| rd_zero_i | input | 1 | Destination index is zero |
| retire_i | input | 1 | One instruction retires this cycle |
| rdata_o | output | 32 | Old value of the addressed register |
| wb_en_o | output | 1 | Write `rdata_o` to the destination register |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
On every cycle, the assertions check the suppression rules. These are: no write-back on an illegal access or with a zero destination, no write for a set or clear with a zero source field, and no write while idle. They also check that an illegal access leaves the scratch and counter state unchanged, that the hart number never moves after reset, and the increment-or-write rule of both counters. The bench scenarios are needed to show the actual read-modify-write arithmetic, the zero extension of the immediate, the address decode, the same-cycle old-value return and the wrap of the cycle counter. They also cover the captured hart number and the reset values, because each of these needs a known stimulus history to predict.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [1:0] {
    CSR_OP_NONE  = 2'd0,
    CSR_OP_WRITE = 2'd1,
    CSR_OP_SET   = 2'd2,
    CSR_OP_CLEAR = 2'd3
  } csr_op_e;

  localparam int unsigned CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_SCRATCH = 12'h340;
  localparam logic [CSR_AW-1:0] ADDR_HARTNUM = 12'hF14;
  localparam logic [CSR_AW-1:0] ADDR_CYCLE   = 12'hB00;
  localparam logic [CSR_AW-1:0] ADDR_RETIRED = 12'hB02;

  // New register value from the old value and the operand.
  function automatic logic [31:0] csr_apply(csr_op_e op, logic [31:0] old_v,
                                            logic [31:0] opnd);
    case (op)
      CSR_OP_WRITE: csr_apply = opnd;
      CSR_OP_SET:   csr_apply = old_v | opnd;
      CSR_OP_CLEAR: csr_apply = old_v & ~opnd;
      default:      csr_apply = old_v;
    endcase
  endfunction

  // Top two address bits both set marks a read-only register.
  function automatic logic csr_is_ro(logic [CSR_AW-1:0] a);
    csr_is_ro = (a[11:10] == 2'b11);
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned FLDW = 5
) (
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [FLDW-1:0] rs1_fld_i,
  input  logic            rd_zero_i,
  output csr_op_e         op_o,
  output logic [XLEN-1:0] operand_o,
  output logic            want_read_o,
  output logic            want_write_o,
  output logic            bad_funct_o
);
  logic fld_zero;
  assign fld_zero = (rs1_fld_i == '0);

  always_comb begin
    op_o         = csr_op_e'(funct3_i[1:0]);
    bad_funct_o  = (funct3_i[1:0] == 2'b00);
    operand_o    = funct3_i[2] ? {{(XLEN-FLDW){1'b0}}, rs1_fld_i} : rs1_val_i;
    want_read_o  = 1'b0;
    want_write_o = 1'b0;
    if (!bad_funct_o) begin
      if (op_o == CSR_OP_WRITE) begin
        want_write_o = 1'b1;
        want_read_o  = !rd_zero_i;
      end else begin
        want_write_o = !fld_zero;
        want_read_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count_o <= '0;
    else if (wr_i)  count_o <= wdata_i;
    else if (inc_i) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   hart_id_i,
  input  logic [CSR_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic              retire_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              hit_o,
  output logic [XLEN-1:0]   scratch_o,
  output logic [XLEN-1:0]   hartnum_o,
  output logic [XLEN-1:0]   cycle_o,
  output logic [XLEN-1:0]   retired_o,
  output logic              wr_cycle_o,
  output logic              wr_retired_o
);
  localparam int unsigned NCNT = 2;
  localparam logic [NCNT-1:0][CSR_AW-1:0] CNT_ADDR = {ADDR_RETIRED, ADDR_CYCLE};

  logic [NCNT-1:0]           cnt_inc;
  logic [NCNT-1:0]           cnt_wr;
  logic [NCNT-1:0][XLEN-1:0] cnt_val;

  assign cnt_inc = {retire_i, 1'b1};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cnt_wr[i] = wr_en_i && (addr_i == CNT_ADDR[i]);
    csr_counter #(.W(XLEN)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (cnt_inc[i]),
      .wr_i    (cnt_wr[i]),
      .wdata_i (wdata_i),
      .count_o (cnt_val[i])
    );
  end

  assign cycle_o      = cnt_val[0];
  assign retired_o    = cnt_val[1];
  assign wr_cycle_o   = cnt_wr[0];
  assign wr_retired_o = cnt_wr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_o <= '0;
      hartnum_o <= hart_id_i;
    end else if (wr_en_i && addr_i == ADDR_SCRATCH) begin
      scratch_o <= wdata_i;
    end
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (addr_i)
      ADDR_SCRATCH: rdata_o = scratch_o;
      ADDR_HARTNUM: rdata_o = hartnum_o;
      ADDR_CYCLE:   rdata_o = cycle_o;
      ADDR_RETIRED: rdata_o = retired_o;
      default:      hit_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] hart_id_i,
  input  logic            valid_i,
  input  logic [2:0]      funct3_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      rs1_fld_i,
  input  logic            rd_zero_i,
  input  logic            retire_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            wb_en_o,
  output logic            illegal_o
);
  csr_op_e         op;
  logic [XLEN-1:0] operand;
  logic            want_read;
  logic            want_write;
  logic            bad_funct;
  logic            hit;
  logic            wr_fire;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;
  logic [XLEN-1:0] scratch_q;
  logic [XLEN-1:0] hartnum_q;
  logic [XLEN-1:0] cycle_q;
  logic [XLEN-1:0] retired_q;
  logic            wr_cycle;
  logic            wr_retired;

  csr_decode #(.XLEN(XLEN), .FLDW(5)) u_dec (
    .funct3_i     (funct3_i),
    .rs1_val_i    (rs1_val_i),
    .rs1_fld_i    (rs1_fld_i),
    .rd_zero_i    (rd_zero_i),
    .op_o         (op),
    .operand_o    (operand),
    .want_read_o  (want_read),
    .want_write_o (want_write),
    .bad_funct_o  (bad_funct)
  );

  assign illegal_o = valid_i && (bad_funct || !hit || (want_write && csr_is_ro(addr_i)));
  assign wr_fire   = valid_i && !illegal_o && want_write;
  assign wb_en_o   = valid_i && !illegal_o && !rd_zero_i && want_read;
  assign new_val   = csr_apply(op, old_val, operand);
  assign rdata_o   = old_val;

  csr_file #(.XLEN(XLEN)) u_file (
    .clk          (clk),
    .rst_n        (rst_n),
    .hart_id_i    (hart_id_i),
    .addr_i       (addr_i),
    .wr_en_i      (wr_fire),
    .wdata_i      (new_val),
    .retire_i     (retire_i),
    .rdata_o      (old_val),
    .hit_o        (hit),
    .scratch_o    (scratch_q),
    .hartnum_o    (hartnum_q),
    .cycle_o      (cycle_q),
    .retired_o    (retired_q),
    .wr_cycle_o   (wr_cycle),
    .wr_retired_o (wr_retired)
  );
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [2:0]      funct3_i,
  input logic [4:0]      rs1_fld_i,
  input logic            rd_zero_i,
  input logic            retire_i,
  input logic            wb_en_o,
  input logic            illegal_o,
  input logic            wr_fire,
  input logic [XLEN-1:0] new_val,
  input logic [XLEN-1:0] scratch_q,
  input logic [XLEN-1:0] hartnum_q,
  input logic [XLEN-1:0] cycle_q,
  input logic [XLEN-1:0] retired_q,
  input logic            wr_cycle,
  input logic            wr_retired
);
  assert_illegal_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wb_en_o);

  assert_rd_zero_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero_i |-> !wb_en_o);

  assert_setclr_zero_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1] && rs1_fld_i == 5'd0) |-> !wr_fire);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!wr_fire && !wb_en_o && !illegal_o));

  assert_illegal_keeps_scratch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(scratch_q));

  assert_illegal_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!wr_cycle && !wr_retired));

  assert_hartnum_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(hartnum_q));

  assert_cycle_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cycle |=> cycle_q == $past(cycle_q) + XLEN'(1));

  assert_cycle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cycle |=> cycle_q == $past(new_val));

  assert_retired_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_retired |=> retired_q == $past(retired_q) + XLEN'($past(retire_i)));

  assert_retired_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_retired |=> retired_q == $past(new_val));
endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_i    (valid_i),
  .funct3_i   (funct3_i),
  .rs1_fld_i  (rs1_fld_i),
  .rd_zero_i  (rd_zero_i),
  .retire_i   (retire_i),
  .wb_en_o    (wb_en_o),
  .illegal_o  (illegal_o),
  .wr_fire    (wr_fire),
  .new_val    (new_val),
  .scratch_q  (scratch_q),
  .hartnum_q  (hartnum_q),
  .cycle_q    (cycle_q),
  .retired_q  (retired_q),
  .wr_cycle   (wr_cycle),
  .wr_retired (wr_retired)
);

// File: tb/tb_csr_unit.sv
module tb_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HART_A = 32'h0000_0007;

  typedef struct packed {
    logic [2:0]  f3;
    logic [11:0] adr;
    logic [31:0] val;
    logic [4:0]  fld;
    logic        rdz;
    logic        chk;
    logic [31:0] exp;
    logic        wb;
    logic        ill;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 19;
  // Walked in order against the scratch register (0x340), which starts at zero.
  localparam vec_t VECS [NV] = '{
    '{3'd1, 12'h340, 32'hA5A50F0F, 5'd3,  1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 8'd11}, // R11 reset, R2 write
    '{3'd2, 12'h340, 32'h000000F0, 5'd4,  1'b0, 1'b1, 32'hA5A50F0F, 1'b1, 1'b0, 8'd2},  // R2 set
    '{3'd3, 12'h340, 32'hA5000000, 5'd5,  1'b0, 1'b1, 32'hA5A50FFF, 1'b1, 1'b0, 8'd2},  // R2 clear
    '{3'd2, 12'h340, 32'hFFFFFFFF, 5'd0,  1'b0, 1'b1, 32'h00A50FFF, 1'b1, 1'b0, 8'd5},  // R5 pure read
    '{3'd7, 12'h340, 32'hDEADBEEF, 5'h0F, 1'b0, 1'b1, 32'h00A50FFF, 1'b1, 1'b0, 8'd5},  // R5 checked by next
    '{3'd6, 12'h340, 32'hDEADBEEF, 5'h15, 1'b0, 1'b1, 32'h00A50FF0, 1'b1, 1'b0, 8'd3},  // R3 imm clear result
    '{3'd5, 12'h340, 32'hDEADBEEF, 5'h1F, 1'b1, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd4},  // R4 write, no wb
    '{3'd1, 12'h340, 32'h12345678, 5'd1,  1'b0, 1'b1, 32'h0000001F, 1'b1, 1'b0, 8'd3},  // R3 R4 zero-ext write
    '{3'd1, 12'hF14, 32'h00000005, 5'd2,  1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 8'd7},  // R7 ro write
    '{3'd2, 12'h340, 32'h00000000, 5'd0,  1'b0, 1'b1, 32'h12345678, 1'b1, 1'b0, 8'd7},  // R7 unchanged
    '{3'd2, 12'h7C0, 32'h00000000, 5'd0,  1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 8'd1},  // R1 unimplemented
    '{3'd2, 12'hF14, 32'h00000000, 5'd0,  1'b0, 1'b1, HART_A,       1'b1, 1'b0, 8'd8},  // R8 captured number
    '{3'd6, 12'hF14, 32'h00000000, 5'd3,  1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 8'd7},  // R7 ro imm set
    '{3'd3, 12'h340, 32'hFFFFFFFF, 5'd0,  1'b1, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 rd zero
    '{3'd2, 12'h340, 32'h00000000, 5'd0,  1'b0, 1'b1, 32'h12345678, 1'b1, 1'b0, 8'd5},  // R5 no change
    '{3'd0, 12'h340, 32'h00000000, 5'd1,  1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 8'd2},  // R2 opcode 0
    '{3'd4, 12'h340, 32'h00000000, 5'd1,  1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 8'd2},  // R2 opcode 4
    '{3'd7, 12'h340, 32'h00000000, 5'd0,  1'b0, 1'b1, 32'h12345678, 1'b1, 1'b0, 8'd7},  // R7 state kept
    '{3'd2, 12'hB02, 32'h00000000, 5'd0,  1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 8'd10}  // R10 R11 no retires yet
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hart_id_i = HART_A;
  logic        valid_i = 1'b0;
  logic [2:0]  funct3_i = '0;
  logic [11:0] addr_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [4:0]  rs1_fld_i = '0;
  logic        rd_zero_i = 1'b0;
  logic        retire_i = 1'b0;
  logic [31:0] rdata_o;
  logic        wb_en_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_unit dut (
    .clk(clk), .rst_n(rst_n), .hart_id_i(hart_id_i), .valid_i(valid_i),
    .funct3_i(funct3_i), .addr_i(addr_i), .rs1_val_i(rs1_val_i),
    .rs1_fld_i(rs1_fld_i), .rd_zero_i(rd_zero_i), .retire_i(retire_i),
    .rdata_o(rdata_o), .wb_en_o(wb_en_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, sample 1 time unit later, before the rising edge.
  task automatic drive(logic v, logic [2:0] f3, logic [11:0] a, logic [31:0] val,
                       logic [4:0] fld, logic rdz, logic ret);
    @(negedge clk);
    valid_i = v; funct3_i = f3; addr_i = a; rs1_val_i = val;
    rs1_fld_i = fld; rd_zero_i = rdz; retire_i = ret;
    #1;
  endtask

  task automatic rd(logic [11:0] a);
    drive(1'b1, 3'd2, a, 32'h0, 5'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    hart_id_i = 32'hBADC0DE5; // R8: changing after reset must not show
    #1;
    check("R12 idle wb", {31'b0, wb_en_o}, 32'h0);
    check("R12 idle illegal", {31'b0, illegal_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].f3, VECS[i].adr, VECS[i].val, VECS[i].fld, VECS[i].rdz, 1'b0);
      check($sformatf("R%0d vec%0d wb", VECS[i].tag, i), {31'b0, wb_en_o}, {31'b0, VECS[i].wb});
      check($sformatf("R%0d vec%0d illegal", VECS[i].tag, i), {31'b0, illegal_o}, {31'b0, VECS[i].ill});
      if (VECS[i].chk)
        check($sformatf("R%0d vec%0d rdata", VECS[i].tag, i), rdata_o, VECS[i].exp);
    end

    // R12: an idle cycle carrying a write pattern changes nothing
    drive(1'b0, 3'd1, 12'h340, 32'hFFFF0000, 5'd1, 1'b0, 1'b0);
    check("R12 idle wb", {31'b0, wb_en_o}, 32'h0);
    rd(12'h340);
    check("R12 scratch untouched", rdata_o, 32'h12345678);

    // R9: consecutive reads step by one
    rd(12'hB00);
    c0 = rdata_o;
    rd(12'hB00);
    check("R9 cycle step", rdata_o, c0 + 32'd1);

    // R9: write wins over increment, then counting resumes
    drive(1'b1, 3'd1, 12'hB00, 32'h00000100, 5'd1, 1'b1, 1'b0);
    rd(12'hB00);
    check("R9 cycle write", rdata_o, 32'h00000100);
    rd(12'hB00);
    check("R9 cycle after write", rdata_o, 32'h00000101);

    // R9: wrap
    drive(1'b1, 3'd1, 12'hB00, 32'hFFFFFFFF, 5'd1, 1'b1, 1'b0);
    rd(12'hB00);
    check("R9 cycle at max", rdata_o, 32'hFFFFFFFF);
    rd(12'hB00);
    check("R9 cycle wrap", rdata_o, 32'h00000000);

    // R10: three retire pulses
    drive(1'b0, 3'd0, 12'h0, 32'h0, 5'd0, 1'b0, 1'b1);
    drive(1'b0, 3'd0, 12'h0, 32'h0, 5'd0, 1'b0, 1'b1);
    drive(1'b0, 3'd0, 12'h0, 32'h0, 5'd0, 1'b0, 1'b1);
    rd(12'hB02);
    check("R10 retired count", rdata_o, 32'd3);

    // R10: write with a retire pulse in the same cycle
    drive(1'b1, 3'd5, 12'hB02, 32'h0, 5'd20, 1'b1, 1'b1);
    rd(12'hB02);
    check("R10 retired write wins", rdata_o, 32'd20);

    // R3: register-operand form ignores the field; immediate form ignores the value
    drive(1'b1, 3'd1, 12'h340, 32'h0000F000, 5'd7, 1'b1, 1'b0);
    rd(12'h340);
    check("R3 register operand", rdata_o, 32'h0000F000);
    drive(1'b1, 3'd6, 12'h340, 32'hFFFFFFFF, 5'd9, 1'b1, 1'b0);
    rd(12'h340);
    check("R3 immediate set", rdata_o, 32'h0000F009);

    // R8: hart number held after reset
    rd(12'hF14);
    check("R8 hart number held", rdata_o, HART_A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule